// File: doc/BRIEF.md
# SPI Master with Bypassable FIFOs

This block is an SPI master for a CPU-facing register interface. Software sends characters through one transmit port and collects received characters through one receive port. It never addresses a storage slot directly. A mode input selects where those ports lead:

- **FIFO mode:** a hidden 16-entry transmit queue and a hidden 16-entry receive queue.
- **Single-buffer mode:** one transmit holding register and one receive holding register. While this mode is active, both queues are kept cleared and report a level of zero.

The serial side runs SPI mode 0 from a fixed clock divider:

- SCLK idles low.
- The controller samples MISO on the rising edge and changes MOSI on the falling edge.
- An active-low chip select frames each burst of characters.

The character length is programmable from 1 to 16 bits. The block latches the length when a character enters the shifter, so software may change it between characters. It should wait for the completion flag before doing so.

The block reports four status items: a completion flag, both queue levels, a sticky transmit-overflow flag and a sticky receive-overrun flag.

The transmit port uses `tx_valid`/`tx_ready`. A beat with both high is accepted. A beat with `tx_valid` high and `tx_ready` low is not held off; it is discarded and flagged. Software is therefore expected to check `tx_ready` (queue not full, or holding register empty) before writing.

The receive port uses `rx_valid`/`rx_ready`. `rx_valid` shows that a word is waiting. A cycle with both high consumes the oldest word. The serial side cannot be held off: a completed character that finds no room is dropped and flagged.

Top module: `spi_fifo_master`

## Requirements
- R1: With `cfg_fifo_en`=1, every accepted transmit beat is queued, `tx_level` counts the queued words, and characters go out in the order written.
- R2: With `cfg_fifo_en`=1, a receive beat (`rx_valid` and `rx_ready` high) removes the oldest received word, so words come out in the order received.
- R3: Each queue holds 16 words. A transmit beat while the transmit queue is full is ignored and sets `tx_ovf`. `tx_ovf` stays set until a cycle with `flag_clr`=1.
- R4: While `cfg_fifo_en`=0, both queues are cleared: from the next cycle on, `tx_level` and `rx_level` read 0.
- R5: With `cfg_fifo_en`=0, a transmit beat while the holding register still holds a word not yet taken by the shifter sets `tx_ovf`, and that beat's word is never sent.
- R6: `cfg_char_len` holds the character length minus one (0 means 1 bit, 15 means 16 bits). The block samples it only when a character is loaded into the shifter; a change during a character affects the next one.
- R7: Each character is sent MSB first, starting at bit `cfg_char_len` of the word. The received word is right-justified, and bits above the character length read 0.
- R8: `done_flag` is set when a character has been fully shifted and is cleared by a receive beat. If both happen in the same cycle, the set wins.
- R9: A character that completes while the receive storage is full sets `rx_ovr` and is dropped. Full means the holding register is occupied, or the queue holds 16 words, and no receive beat occurs in that cycle. `rx_ovr` is cleared by `flag_clr`.
- R10: SCLK is low whenever `cs_n` is high. `cs_n` falls one half-period (`HALF_DIV` clocks) before the first rising SCLK edge. It stays low across back-to-back characters and rises at the final falling edge when no word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fifo_en | input | 1 | 1 selects the 16-deep queues, 0 selects single buffers |
| cfg_char_len | input | 4 | Character length minus one |
| flag_clr | input | 1 | Clears `tx_ovf` and `rx_ovr` |
| tx_valid | input | 1 | Transmit write strobe |
| tx_ready | output | 1 | Transmit storage has room |
| tx_data | input | 16 | Transmit word |
| rx_valid | output | 1 | A received word is waiting |
| rx_ready | input | 1 | Consume the oldest received word |
| rx_data | output | 16 | Oldest received word |
| tx_level | output | 5 | Words in the transmit queue |
| rx_level | output | 5 | Words in the receive queue |
| done_flag | output | 1 | Character-complete flag |
| tx_ovf | output | 1 | Sticky transmit overflow/overrun |
| rx_ovr | output | 1 | Sticky receive overrun |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| miso | input | 1 | Serial data in |

## Verification
With MISO looped back to MOSI, a wrong bit counter, a wrong length latch or a wrong shift direction shows up in the first received word, masked or reversed. It is visible as soon as that character's `done_flag` rises. A queue pointer fault shows up as words out of order, or as a wrong level count, within one write or read of the fault. A mode-switch fault shows up as a nonzero level the cycle after single-buffer mode is selected. Framing faults show up on `cs_n` and SCLK: the half-period lead before the first edge, or an extra chip-select rise inside a back-to-back burst, is visible within one character time.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_LOW  = 2'd1,
    SH_HIGH = 2'd2
  } shift_st_e;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && (!full || pop);
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int HALF_DIV = 2,
  localparam int LEN_W   = $clog2(DATA_W),
  localparam int CNT_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [LEN_W-1:0]  ld_len,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);
  shift_st_e         st;
  logic [CNT_W-1:0]  hcnt;
  logic [LEN_W-1:0]  bitn, len_q;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              half_end, last_bit;

  assign half_end = (hcnt == CNT_W'(HALF_DIV - 1));
  assign last_bit = (bitn == len_q);
  assign ld_ready = (st == SH_IDLE) || (st == SH_HIGH && half_end && last_bit);
  assign mosi     = cs_n ? 1'b0 : tx_sh[len_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SH_IDLE;
      hcnt    <= '0;
      bitn    <= '0;
      len_q   <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (ld_valid) begin
            tx_sh <= ld_data;
            len_q <= ld_len;
            rx_sh <= '0;
            bitn  <= '0;
            hcnt  <= '0;
            cs_n  <= 1'b0;
            st    <= SH_LOW;
          end
        end
        SH_LOW: begin
          if (half_end) begin
            hcnt  <= '0;
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[DATA_W-2:0], miso};
            st    <= SH_HIGH;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        SH_HIGH: begin
          if (half_end) begin
            hcnt <= '0;
            sclk <= 1'b0;
            if (last_bit) begin
              done    <= 1'b1;
              rx_word <= rx_sh;
              if (ld_valid) begin
                tx_sh <= ld_data;
                len_q <= ld_len;
                rx_sh <= '0;
                bitn  <= '0;
                st    <= SH_LOW;
              end else begin
                cs_n <= 1'b1;
                st   <= SH_IDLE;
              end
            end else begin
              bitn  <= bitn + 1'b1;
              tx_sh <= tx_sh << 1;
              st    <= SH_LOW;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int HALF_DIV = 2,
  localparam int LEN_W   = $clog2(DATA_W),
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fifo_en,
  input  logic [LEN_W-1:0]  cfg_char_len,
  input  logic              flag_clr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic [LVL_W-1:0]  tx_level,
  output logic [LVL_W-1:0]  rx_level,
  output logic              done_flag,
  output logic              tx_ovf,
  output logic              rx_ovr,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);
  // transmit side
  logic [DATA_W-1:0] tf_dout, th_d, src_data;
  logic              tf_full, tf_empty, th_v;
  logic              src_valid, ld_ready, ld_take, wr_ok;

  // receive side
  logic [DATA_W-1:0] rf_dout, rh_d, chr_word;
  logic              rf_full, rf_empty, rh_v, chr_done, rx_pop;

  assign tx_ready  = cfg_fifo_en ? !tf_full : !th_v;
  assign wr_ok     = tx_valid && tx_ready;
  assign src_valid = cfg_fifo_en ? !tf_empty : th_v;
  assign src_data  = cfg_fifo_en ? tf_dout : th_d;
  assign ld_take   = src_valid && ld_ready;

  spi_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_q (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!cfg_fifo_en),
    .push  (cfg_fifo_en && wr_ok),
    .pop   (cfg_fifo_en && ld_take),
    .din   (tx_data),
    .dout  (tf_dout),
    .count (tx_level),
    .full  (tf_full),
    .empty (tf_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_v <= 1'b0;
      th_d <= '0;
    end else if (cfg_fifo_en) begin
      th_v <= 1'b0;
    end else if (wr_ok) begin
      th_v <= 1'b1;
      th_d <= tx_data;
    end else if (ld_take) begin
      th_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tx_ovf <= 1'b0;
    else if (tx_valid && !tx_ready) tx_ovf <= 1'b1;
    else if (flag_clr)             tx_ovf <= 1'b0;
  end

  spi_shift_engine #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (src_valid),
    .ld_ready (ld_ready),
    .ld_data  (src_data),
    .ld_len   (cfg_char_len),
    .done     (chr_done),
    .rx_word  (chr_word),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .miso     (miso)
  );

  assign rx_valid = cfg_fifo_en ? !rf_empty : rh_v;
  assign rx_data  = cfg_fifo_en ? rf_dout : rh_d;
  assign rx_pop   = rx_valid && rx_ready;

  spi_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_q (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!cfg_fifo_en),
    .push  (cfg_fifo_en && chr_done),
    .pop   (cfg_fifo_en && rx_pop),
    .din   (chr_word),
    .dout  (rf_dout),
    .count (rx_level),
    .full  (rf_full),
    .empty (rf_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh_v <= 1'b0;
      rh_d <= '0;
    end else if (cfg_fifo_en) begin
      rh_v <= 1'b0;
    end else if (chr_done && (!rh_v || rx_pop)) begin
      rh_v <= 1'b1;
      rh_d <= chr_word;
    end else if (rx_pop) begin
      rh_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ovr    <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (chr_done && (cfg_fifo_en ? (rf_full && !rx_pop) : (rh_v && !rx_pop)))
        rx_ovr <= 1'b1;
      else if (flag_clr)
        rx_ovr <= 1'b0;
      if (chr_done)    done_flag <= 1'b1;
      else if (rx_pop) done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_fifo_en,
  input logic             flag_clr,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             done_flag,
  input logic             tx_ovf,
  input logic             rx_ovr,
  input logic             sclk,
  input logic             cs_n,
  input logic             chr_done
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

  a_r3_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fifo_en && tx_valid && !tx_ready) |=> tx_ovf);

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !flag_clr) |=> tx_ovf);

  a_r4_levels_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fifo_en |=> (tx_level == '0) && (rx_level == '0));

  a_r5_single_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fifo_en && tx_valid && !tx_ready) |=> tx_ovf);

  a_r8_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    chr_done |=> done_flag);

  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !chr_done) |=> !done_flag);

  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !flag_clr) |=> rx_ovr);

  a_r10_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_fifo_en (cfg_fifo_en),
  .flag_clr    (flag_clr),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .tx_level    (tx_level),
  .rx_level    (rx_level),
  .done_flag   (done_flag),
  .tx_ovf      (tx_ovf),
  .rx_ovr      (rx_ovr),
  .sclk        (sclk),
  .cs_n        (cs_n),
  .chr_done    (chr_done)
);

// File: tb/spi_fifo_master_tb.sv
`timescale 1ns/1ps
module spi_fifo_master_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_fifo_en = 1'b0;
  logic [3:0]  cfg_char_len = 4'd7;
  logic        flag_clr = 1'b0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic        rx_ready = 1'b0;
  logic        tx_ready, rx_valid, done_flag, tx_ovf, rx_ovr, sclk, mosi, cs_n;
  logic [15:0] rx_data;
  logic [4:0]  tx_level, rx_level;

  int checks = 0;
  int fails  = 0;
  int sclk_rises = 0;
  int cs_rises = 0;
  bit lead_armed = 0;
  realtime t_cs = 0, t_first = 0;

  always #4 clk = ~clk;

  spi_fifo_master #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_char_len(cfg_char_len),
    .flag_clr(flag_clr), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .tx_level(tx_level),
    .rx_level(rx_level), .done_flag(done_flag), .tx_ovf(tx_ovf), .rx_ovr(rx_ovr),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(mosi)
  );

  always @(posedge sclk) begin
    sclk_rises++;
    if (lead_armed) begin
      t_first = $realtime;
      lead_armed = 0;
    end
  end
  always @(negedge cs_n) begin
    t_cs = $realtime;
    lead_armed = 1;
  end
  always @(posedge cs_n) cs_rises++;

  function automatic logic [15:0] expect_rx(input logic [15:0] w, input int len);
    logic [31:0] m;
    m = (32'h1 << (len + 1)) - 1;
    return w & m[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic [15:0] w);
    @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic read_word(input logic [15:0] exp, input string tag);
    @(negedge clk);
    check(rx_valid === 1'b1, {tag, " rx_valid"}, int'(rx_valid), 1);
    check(rx_data === exp, tag, int'(rx_data), int'(exp));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!(cs_n === 1'b1 && tx_level == 0 && tx_ready === 1'b1)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] wq [20];
    int e0, c0, len, n;
    void'($urandom(32'h1f2e3d4c));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sclk_rises = 0;
    cs_rises = 0;

    // reset state
    check(cs_n === 1'b1 && sclk === 1'b0, "R10 reset framing", int'({cs_n, sclk}), 2);
    check(tx_level == 0 && rx_level == 0, "R4 reset levels", int'({tx_level, rx_level}), 0);
    check(done_flag === 1'b0 && tx_ovf === 1'b0 && rx_ovr === 1'b0, "R8 reset flags",
          int'({done_flag, tx_ovf, rx_ovr}), 0);
    check(tx_ready === 1'b1 && rx_valid === 1'b0, "R5 reset handshake", int'({tx_ready, rx_valid}), 2);

    // single-buffer, 8-bit character
    cfg_char_len = 4'd7;
    write_word(16'hA5C3);
    wait_idle();
    check(done_flag === 1'b1, "R8 done set", int'(done_flag), 1);
    check(t_first - t_cs == HALF * 8.0, "R10 cs lead", int'(t_first - t_cs), HALF * 8);
    check(sclk_rises == 8, "R6 edge count len8", sclk_rises, 8);
    read_word(16'h00C3, "R7 8-bit right-justified");
    check(done_flag === 1'b0, "R8 done cleared by read", int'(done_flag), 0);

    // single-buffer overrun: two consecutive write beats
    @(negedge clk);
    e0 = sclk_rises;
    tx_data = 16'h1234; tx_valid = 1'b1;
    @(negedge clk);
    tx_data = 16'h5678;
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ovf === 1'b1, "R5 tx overrun flag", int'(tx_ovf), 1);
    check(tx_level == 0 && rx_level == 0, "R4 levels zero single mode", int'({tx_level, rx_level}), 0);
    wait_idle();
    check(sclk_rises - e0 == 8, "R5 dropped word not sent", sclk_rises - e0, 8);
    read_word(16'h0034, "R5 first word kept");
    check(rx_valid === 1'b0, "R5 nothing else received", int'(rx_valid), 0);
    pulse_clr();
    check(tx_ovf === 1'b0, "R3 flag clear", int'(tx_ovf), 0);

    // length change during a character
    cfg_char_len = 4'd15;
    @(negedge clk);
    tx_data = 16'h8E01; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (10) @(negedge clk);
    cfg_char_len = 4'd3;
    wait_idle();
    read_word(16'h8E01, "R6 mid-char change ignored");
    write_word(16'h00FE);
    wait_idle();
    read_word(16'h000E, "R6 new length used");

    // 1-bit characters
    cfg_char_len = 4'd0;
    write_word(16'h0001);
    wait_idle();
    read_word(16'h0001, "R7 1-bit one");
    write_word(16'hFFFE);
    wait_idle();
    read_word(16'h0000, "R7 1-bit zero");

    // single-buffer receive overrun
    cfg_char_len = 4'd7;
    write_word(16'h0011);
    wait_idle();
    write_word(16'h0022);
    wait_idle();
    check(rx_ovr === 1'b1, "R9 single rx overrun", int'(rx_ovr), 1);
    check(rx_level == 0, "R4 rx level single mode", int'(rx_level), 0);
    read_word(16'h0011, "R9 older word kept");
    check(rx_valid === 1'b0, "R9 new word dropped", int'(rx_valid), 0);
    pulse_clr();
    check(rx_ovr === 1'b0, "R9 rx overrun clear", int'(rx_ovr), 0);

    // FIFO mode: flood with 20 words of 16 bits
    cfg_fifo_en = 1'b1;
    cfg_char_len = 4'd15;
    for (int i = 0; i < 20; i++) wq[i] = 16'($urandom);
    @(negedge clk);
    e0 = sclk_rises;
    c0 = cs_rises;
    for (int i = 0; i < 20; i++) begin
      tx_data = wq[i];
      tx_valid = 1'b1;
      @(negedge clk);
    end
    tx_valid = 1'b0;
    check(tx_level == 16, "R3 tx level full", int'(tx_level), 16);
    check(tx_ready === 1'b0, "R3 tx not ready when full", int'(tx_ready), 0);
    check(tx_ovf === 1'b1, "R3 overflow flag", int'(tx_ovf), 1);
    pulse_clr();
    check(tx_ovf === 1'b0, "R3 overflow cleared", int'(tx_ovf), 0);
    wait_idle();
    check(sclk_rises - e0 == 17 * 16, "R1 17 words sent", sclk_rises - e0, 17 * 16);
    check(cs_rises - c0 == 1, "R10 cs held across burst", cs_rises - c0, 1);
    check(rx_level == 16, "R9 rx queue full", int'(rx_level), 16);
    check(rx_ovr === 1'b1, "R9 fifo rx overrun", int'(rx_ovr), 1);
    for (int i = 0; i < 16; i++) read_word(wq[i], "R2 fifo order");
    check(rx_level == 0 && rx_valid === 1'b0, "R2 rx drained", int'(rx_level), 0);
    pulse_clr();

    // random FIFO bursts
    for (int it = 0; it < 25; it++) begin
      len = int'($urandom_range(0, 15));
      n = int'($urandom_range(1, 6));
      if (it == 0) len = 0;
      if (it == 1) len = 15;
      cfg_char_len = 4'(len);
      for (int i = 0; i < n; i++) wq[i] = 16'($urandom);
      @(negedge clk);
      e0 = sclk_rises;
      c0 = cs_rises;
      for (int i = 0; i < n; i++) begin
        tx_data = wq[i];
        tx_valid = 1'b1;
        @(negedge clk);
      end
      tx_valid = 1'b0;
      wait_idle();
      check(rx_level == 5'(n), "R1 rx level after burst", int'(rx_level), n);
      check(sclk_rises - e0 == n * (len + 1), "R6 edges per burst", sclk_rises - e0, n * (len + 1));
      check(cs_rises - c0 == 1, "R10 one frame per burst", cs_rises - c0, 1);
      check(t_first - t_cs == HALF * 8.0, "R10 lead per burst", int'(t_first - t_cs), HALF * 8);
      for (int i = 0; i < n; i++) read_word(expect_rx(wq[i], len), "R7 random burst data");
    end

    // leaving FIFO mode clears queued data
    cfg_char_len = 4'd7;
    write_word(16'h0055);
    write_word(16'h00AA);
    wait_idle();
    check(rx_level == 2, "R1 two queued", int'(rx_level), 2);
    @(negedge clk);
    cfg_fifo_en = 1'b0;
    @(negedge clk);
    check(rx_level == 0 && tx_level == 0, "R4 queues cleared on mode off", int'(rx_level), 0);
    check(rx_valid === 1'b0, "R4 nothing visible after mode off", int'(rx_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule